// File: doc/BRIEF.md
# Two-Stage Redundant Omega Router

This block joins eight request inputs to eight result outputs through two stages of 4x4 switching boxes, two boxes per stage. A three-bit address takes only three of the four bit positions that two stages of two-bit boxes can carry. The spare position holds a path bit, so every source and destination pair has two physical paths. The two paths share both boxes and differ only in the link between the stages. Each cycle, every input can offer one packet: a valid flag, a three-bit destination and a data word. Each output reports, one clock later, a valid flag, the index of the source that reached it, and the data.

Two fault masks describe the fabric: one bit per switching box and one bit per inter-stage link. The allocator serves requests in ascending input order. It gives each request a free, healthy link in its group and a free destination, or reports the request as blocked. A request for which no healthy path exists is reported as unroutable. The path bit that is tried first alternates from cycle to cycle, so traffic spreads over both links while the fabric is healthy. Which link carries a packet never changes which packets get through.

Top module: `omrt_router`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, every `out_valid` bit is 0. With no valid inputs, every `out_valid` bit stays 0.
- R2: Input index i is encoded as bits (n1,n2,n3) = (i[2],i[1],i[0]), and a destination tag d as (m1,m2,m3) = (d[2],d[1],d[0]). A request that is neither blocked nor unroutable in a cycle appears on output d in the next cycle, with `out_src` = i and `out_data` equal to the input data.
- R3: When several routable requests target the same destination, the lowest input index is delivered. Every other request for that destination asserts `in_blocked` in the same cycle and is not delivered.
- R4: `box_fault` bit i[0] marks the first-stage box of input i, and bit 2+d[1] marks the second-stage box of destination d. A valid request whose first-stage or second-stage box is faulty asserts `in_unroutable`, is not blocked, and is not delivered.
- R5: Link index {r,d[1],i[0]} (r as the MSB) names the inter-stage link for path bit r. If exactly one of a request's two links is faulty, the request is delivered over the other link.
- R6: If both links of a request's group {d[1],i[0]} are faulty, the request asserts `in_unroutable` and is not delivered.
- R7: Requests that share i[0] and d[1] compete for the two links of their group. Among the requests that win their destination, the two lowest-indexed ones are delivered, and later ones assert `in_blocked`.
- R8: An output is valid only if some valid input requested it in the previous cycle. `in_blocked` and `in_unroutable` are never both set and are set only for valid inputs. No first-stage input port drives more than one box output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 8 | Request present, one bit per input |
| in_dest | input | 8x3 | Destination tag per input |
| in_data | input | 8xDATA_W | Data word per input |
| box_fault | input | 4 | Faulty-box mask: bits 0..1 first stage, bits 2..3 second stage |
| link_fault | input | 8 | Faulty inter-stage link mask, indexed {r,m2,n3} |
| in_blocked | output | 8 | Request lost to contention this cycle |
| in_unroutable | output | 8 | Request has no healthy path this cycle |
| out_valid | output | 8 | Registered result present per output |
| out_src | output | 8x3 | Source index of the registered result |
| out_data | output | 8xDATA_W | Registered data word |

## Verification
On every cycle, the assertions check several things. A granted request lands on its destination one clock later with the right source and data. A faulty box always makes its requests unroutable. The two status flags are exclusive. Inside each box, the crossbar selects are consistent with one another. Two orderings can only be shown by scenarios in the bench: the lowest-index order in which destinations and links are shared out, and the rerouting around single faulty links. The bench covers these with directed contention and fault patterns, and with randomly masked traffic that it compares against a count-based model.

// File: rtl/omrt_pkg.sv
package omrt_pkg;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned N_TERM    = 1 << ADDR_W;
  localparam int unsigned BOX_PORTS = 4;
  localparam int unsigned SEL_W     = $clog2(BOX_PORTS);
  localparam int unsigned N_BOXES   = 4;
  localparam int unsigned N_LINK    = N_TERM;
endpackage

// File: rtl/omrt_xbar.sv
module omrt_xbar
  import omrt_pkg::*;
#(
  parameter int unsigned PAY_W = 19
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [BOX_PORTS-1:0]                  in_vld,
  input  logic [BOX_PORTS-1:0][PAY_W-1:0]       in_pay,
  input  logic [BOX_PORTS-1:0]                  out_en,
  input  logic [BOX_PORTS-1:0][SEL_W-1:0]       out_sel,
  output logic [BOX_PORTS-1:0]                  out_vld,
  output logic [BOX_PORTS-1:0][PAY_W-1:0]       out_pay
);
  logic [BOX_PORTS-1:0][BOX_PORTS-1:0] use_map;

  always_comb begin
    for (int o = 0; o < BOX_PORTS; o++) begin
      out_vld[o] = out_en[o] & in_vld[out_sel[o]];
      out_pay[o] = out_en[o] ? in_pay[out_sel[o]] : '0;
    end
    for (int p = 0; p < BOX_PORTS; p++) begin
      for (int o = 0; o < BOX_PORTS; o++) begin
        use_map[p][o] = out_en[o] && (out_sel[o] == SEL_W'(p));
      end
    end
  end

  for (genvar p = 0; p < BOX_PORTS; p++) begin : g_port_chk
    // R8: one input port feeds at most one box output
    p_port_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(use_map[p]) <= 1);
  end
  for (genvar o = 0; o < BOX_PORTS; o++) begin : g_out_chk
    // R8: an enabled output always selects a live input
    p_sel_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_en[o] |-> in_vld[out_sel[o]]);
  end
endmodule

// File: rtl/omrt_alloc.sv
module omrt_alloc
  import omrt_pkg::*;
(
  input  logic [N_TERM-1:0]              in_valid,
  input  logic [N_TERM-1:0][ADDR_W-1:0]  in_dest,
  input  logic [N_BOXES-1:0]             box_fault,
  input  logic [N_LINK-1:0]              link_fault,
  input  logic                           pref,
  output logic [N_TERM-1:0]              blocked,
  output logic [N_TERM-1:0]              unroutable,
  output logic [N_LINK-1:0]              link_en,
  output logic [N_LINK-1:0][SEL_W-1:0]   link_port,
  output logic [N_TERM-1:0]              dst_en,
  output logic [N_TERM-1:0][SEL_W-1:0]   dst_port
);
  logic [N_TERM-1:0] dest_busy;
  logic [N_LINK-1:0] link_busy;

  always_comb begin
    dest_busy  = '0;
    link_busy  = '0;
    blocked    = '0;
    unroutable = '0;
    link_en    = '0;
    link_port  = '0;
    dst_en     = '0;
    dst_port   = '0;
    for (int i = 0; i < N_TERM; i++) begin
      logic       b, c, got, r;
      logic [2:0] l_try, l_alt, l_sel;
      logic       ok_box, h_try, h_alt;
      b      = i[0];
      c      = in_dest[i][1];
      l_try  = {pref, c, b};
      l_alt  = {~pref, c, b};
      h_try  = ~link_fault[l_try];
      h_alt  = ~link_fault[l_alt];
      ok_box = ~box_fault[{1'b0, b}] & ~box_fault[{1'b1, c}];
      got    = 1'b0;
      r      = pref;
      l_sel  = l_try;
      if (in_valid[i]) begin
        if (!(ok_box && (h_try || h_alt))) begin
          unroutable[i] = 1'b1;
        end else if (dest_busy[in_dest[i]]) begin
          blocked[i] = 1'b1;
        end else if (h_try && !link_busy[l_try]) begin
          got = 1'b1;
        end else if (h_alt && !link_busy[l_alt]) begin
          got   = 1'b1;
          r     = ~pref;
          l_sel = l_alt;
        end else begin
          blocked[i] = 1'b1;
        end
      end
      if (got) begin
        link_busy[l_sel]      = 1'b1;
        link_en[l_sel]        = 1'b1;
        link_port[l_sel]      = i[2:1];
        dest_busy[in_dest[i]] = 1'b1;
        dst_en[in_dest[i]]    = 1'b1;
        dst_port[in_dest[i]]  = {b, r};
      end
    end
  end
endmodule

// File: rtl/omrt_router.sv
module omrt_router
  import omrt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_TERM-1:0]                 in_valid,
  input  logic [N_TERM-1:0][ADDR_W-1:0]     in_dest,
  input  logic [N_TERM-1:0][DATA_W-1:0]     in_data,
  input  logic [N_BOXES-1:0]                box_fault,
  input  logic [N_LINK-1:0]                 link_fault,
  output logic [N_TERM-1:0]                 in_blocked,
  output logic [N_TERM-1:0]                 in_unroutable,
  output logic [N_TERM-1:0]                 out_valid,
  output logic [N_TERM-1:0][ADDR_W-1:0]     out_src,
  output logic [N_TERM-1:0][DATA_W-1:0]     out_data
);
  localparam int unsigned PAY_W = ADDR_W + DATA_W;

  logic [1:0]                        rst_sync_q;
  logic                              rst_sync_n;
  logic                              pref_q, pref_d;
  logic [N_LINK-1:0]                 link_en;
  logic [N_LINK-1:0][SEL_W-1:0]      link_port;
  logic [N_TERM-1:0]                 dst_en;
  logic [N_TERM-1:0][SEL_W-1:0]      dst_port;
  logic [N_LINK-1:0]                 link_vld;
  logic [N_LINK-1:0][PAY_W-1:0]      link_pay;
  logic [N_TERM-1:0]                 fab_vld;
  logic [N_TERM-1:0][PAY_W-1:0]      fab_pay;
  logic [N_TERM-1:0]                 ovld_q, ovld_d;
  logic [N_TERM-1:0][PAY_W-1:0]      opay_q;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // alternating first-choice path bit
  assign pref_d = ~pref_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pref_q <= 1'b0;
    else             pref_q <= pref_d;
  end

  omrt_alloc u_alloc (
    .in_valid   (in_valid),
    .in_dest    (in_dest),
    .box_fault  (box_fault),
    .link_fault (link_fault),
    .pref       (pref_q),
    .blocked    (in_blocked),
    .unroutable (in_unroutable),
    .link_en    (link_en),
    .link_port  (link_port),
    .dst_en     (dst_en),
    .dst_port   (dst_port)
  );

  // stage one: box b serves inputs with n3 = b; port p = (n1,n2); out port (r1,m2)
  for (genvar b = 0; b < 2; b++) begin : g_s1
    logic [BOX_PORTS-1:0]             s_in_vld, s_out_en, s_out_vld;
    logic [BOX_PORTS-1:0][PAY_W-1:0]  s_in_pay, s_out_pay;
    logic [BOX_PORTS-1:0][SEL_W-1:0]  s_out_sel;
    for (genvar p = 0; p < BOX_PORTS; p++) begin : g_p
      assign s_in_vld[p]  = in_valid[p*2+b];
      assign s_in_pay[p]  = {ADDR_W'(p*2+b), in_data[p*2+b]};
      assign s_out_en[p]  = link_en[(p/2)*4 + (p%2)*2 + b];
      assign s_out_sel[p] = link_port[(p/2)*4 + (p%2)*2 + b];
      assign link_vld[(p/2)*4 + (p%2)*2 + b] = s_out_vld[p];
      assign link_pay[(p/2)*4 + (p%2)*2 + b] = s_out_pay[p];
    end
    omrt_xbar #(.PAY_W(PAY_W)) u_box (
      .clk(clk), .rst_n(rst_sync_n),
      .in_vld(s_in_vld), .in_pay(s_in_pay),
      .out_en(s_out_en), .out_sel(s_out_sel),
      .out_vld(s_out_vld), .out_pay(s_out_pay)
    );
  end

  // stage two: box c serves m2 = c; in port (n3,r1); out port (m3,m1)
  for (genvar c = 0; c < 2; c++) begin : g_s2
    logic [BOX_PORTS-1:0]             s_in_vld, s_out_en, s_out_vld;
    logic [BOX_PORTS-1:0][PAY_W-1:0]  s_in_pay, s_out_pay;
    logic [BOX_PORTS-1:0][SEL_W-1:0]  s_out_sel;
    for (genvar q = 0; q < BOX_PORTS; q++) begin : g_q
      assign s_in_vld[q]  = link_vld[(q%2)*4 + c*2 + q/2];
      assign s_in_pay[q]  = link_pay[(q%2)*4 + c*2 + q/2];
      assign s_out_en[q]  = dst_en[(q%2)*4 + c*2 + q/2];
      assign s_out_sel[q] = dst_port[(q%2)*4 + c*2 + q/2];
      assign fab_vld[(q%2)*4 + c*2 + q/2] = s_out_vld[q];
      assign fab_pay[(q%2)*4 + c*2 + q/2] = s_out_pay[q];
    end
    omrt_xbar #(.PAY_W(PAY_W)) u_box (
      .clk(clk), .rst_n(rst_sync_n),
      .in_vld(s_in_vld), .in_pay(s_in_pay),
      .out_en(s_out_en), .out_sel(s_out_sel),
      .out_vld(s_out_vld), .out_pay(s_out_pay)
    );
  end

  // output register stage
  assign ovld_d = fab_vld;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovld_q <= '0;
    else             ovld_q <= ovld_d;
  end
  always_ff @(posedge clk) begin
    for (int d = 0; d < N_TERM; d++) begin
      if (fab_vld[d]) opay_q[d] <= fab_pay[d];
    end
  end

  always_comb begin
    out_valid = ovld_q;
    for (int d = 0; d < N_TERM; d++) begin
      out_src[d]  = opay_q[d][PAY_W-1 -: ADDR_W];
      out_data[d] = opay_q[d][DATA_W-1:0];
    end
  end

  // checks against the ports
  logic [N_TERM-1:0] asked;
  always_comb begin
    asked = '0;
    for (int i = 0; i < N_TERM; i++) if (in_valid[i]) asked[in_dest[i]] = 1'b1;
  end

  for (genvar i = 0; i < N_TERM; i++) begin : g_chk
    // R2: a granted request lands on its destination next cycle
    p_deliver_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid[i] && !in_blocked[i] && !in_unroutable[i]) |=>
        (out_valid[$past(in_dest[i])] &&
         out_src[$past(in_dest[i])] == ADDR_W'(i) &&
         out_data[$past(in_dest[i])] == $past(in_data[i])));
    // R4: a faulty first-stage box leaves its requests unroutable
    p_box_fault_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid[i] && box_fault[i%2]) |-> in_unroutable[i]);
    // R8: status flags exclusive and tied to a valid request
    p_status_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_blocked[i] || in_unroutable[i]) |-> (in_valid[i] && !(in_blocked[i] && in_unroutable[i])));
    // R8: no output without a request
    p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_valid[i] |-> $past(asked[i]));
  end
endmodule

// File: tb/tb_omrt_router.sv
module tb_omrt_router;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]         v;
  logic [7:0][2:0]    dst;
  logic [7:0][DW-1:0] dat;
  logic [3:0]         bf;
  logic [7:0]         lf;
  logic [7:0]         blk, unr, ov;
  logic [7:0][2:0]    osrc;
  logic [7:0][DW-1:0] odat;

  logic [7:0]         e_blk, e_unr, e_ov;
  logic [7:0][2:0]    e_src;
  logic [7:0][DW-1:0] e_dat;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omrt_router #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(v), .in_dest(dst), .in_data(dat),
    .box_fault(bf), .link_fault(lf),
    .in_blocked(blk), .in_unroutable(unr),
    .out_valid(ov), .out_src(osrc), .out_data(odat)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // count-based model: each group (d[1],i[0]) offers one slot per healthy link
  task automatic model();
    int used [4];
    logic [7:0] taken;
    for (int g = 0; g < 4; g++) used[g] = 0;
    taken = '0; e_blk = '0; e_unr = '0; e_ov = '0; e_src = '0; e_dat = '0;
    for (int i = 0; i < 8; i++) begin
      int g, cap;
      g   = (i % 2) + 2 * int'(dst[i][1]);
      cap = (lf[g] ? 0 : 1) + (lf[g+4] ? 0 : 1);
      if (v[i]) begin
        if (bf[i%2] || bf[2 + int'(dst[i][1])] || cap == 0) e_unr[i] = 1'b1;
        else if (taken[dst[i]] || used[g] >= cap) e_blk[i] = 1'b1;
        else begin
          used[g]++;
          taken[dst[i]] = 1'b1;
          e_ov[dst[i]]  = 1'b1;
          e_src[dst[i]] = 3'(i);
          e_dat[dst[i]] = dat[i];
        end
      end
    end
  endtask

  // inputs already driven at a negedge
  task automatic step(input string tag);
    logic [7:0] x_ov;
    logic [7:0][2:0] x_src;
    logic [7:0][DW-1:0] x_dat;
    #1;
    model();
    chk(tag, "in_blocked", 64'(blk), 64'(e_blk));
    chk(tag, "in_unroutable", 64'(unr), 64'(e_unr));
    x_ov = e_ov; x_src = e_src; x_dat = e_dat;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_valid", 64'(ov), 64'(x_ov));
    for (int d = 0; d < 8; d++) begin
      if (x_ov[d]) begin
        chk(tag, $sformatf("out_src[%0d]", d), 64'(osrc[d]), 64'(x_src[d]));
        chk(tag, $sformatf("out_data[%0d]", d), 64'(odat[d]), 64'(x_dat[d]));
      end
    end
  endtask

  task automatic clear();
    v = '0; bf = '0; lf = '0;
    for (int i = 0; i < 8; i++) begin dst[i] = 3'(i); dat[i] = DW'($urandom); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clear();
    rst_n = 1'b0;
    v = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", 64'(ov), 64'h0);
    rst_n = 1'b1;
    v = '0;
    @(negedge clk);
    chk("R1", "out_valid after release", 64'(ov), 64'h0);
    repeat (3) @(negedge clk);
    step("R1");

    // R2 identity and reversal
    clear(); v = 8'hFF; step("R2");
    clear(); v = 8'hFF; for (int i = 0; i < 8; i++) dst[i] = 3'(7 - i); step("R2");
    // R3 everybody to one destination
    clear(); v = 8'hFF; for (int i = 0; i < 8; i++) dst[i] = 3'd5; step("R3");
    clear(); v = 8'b1010_1000; for (int i = 0; i < 8; i++) dst[i] = 3'd2; step("R3");
    // R4 each box faulty in turn
    for (int k = 0; k < 4; k++) begin
      clear(); v = 8'hFF; for (int i = 0; i < 8; i++) dst[i] = 3'((i * 3) % 8);
      bf = 4'(1 << k); step("R4");
    end
    // R5 one link of group 0 down: single request rerouted, then capacity one
    clear(); v = 8'b0000_0001; dst[0] = 3'd0; lf = 8'h01; step("R5");
    clear(); v = 8'b0000_0001; dst[0] = 3'd0; lf = 8'h10; step("R5");
    clear(); v = 8'b0000_0101; dst[0] = 3'd0; dst[2] = 3'd1; lf = 8'h01; step("R5");
    // R6 both links of group 0 down
    clear(); v = 8'hFF; lf = 8'h11; step("R6");
    // R7 four sources with n3=0 heading to m2=0 destinations
    clear(); v = 8'b0101_0101; dst[0] = 3'd0; dst[2] = 3'd1; dst[4] = 3'd4; dst[6] = 3'd5; step("R7");
    step("R7");
    // R8 idle inputs with pending tags
    clear(); for (int i = 0; i < 8; i++) dst[i] = 3'd3; step("R8");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 8; i++) begin
        v[i]   = ($urandom % 4) != 0;
        dst[i] = 3'($urandom);
        dat[i] = DW'($urandom);
      end
      bf = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      lf = (($urandom % 3) == 0) ? 8'($urandom & $urandom) : 8'h00;
      step(n % 2 == 0 ? "R2" : "R8");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule